// File: doc/BRIEF.md
# Three-Wire 24-Bit Register Access Master

This block turns register read and write requests into transfers on a three-wire serial bus with an optional fourth return line. A request enters on a valid/ready command port with an operation code, an 8-bit register index and a 16-bit write value. Every request becomes two 24-bit frames, each shifted out most-significant bit first under its own active-low chip select. The first frame always carries opcode 0x70 followed by the index. For a write, the second frame carries opcode 0x72 and the value. For a read, the second frame carries opcode 0x73 and zeros, and the low 16 bits shifted in during that frame are the result. One response pulse reports the end of every request.

Bit timing comes from parameters counted in system clock cycles. `HALF_CYC` sets each clock phase. `GUARD_CYC` sets the quiet time after chip select falls, the time after the last clock edge before it rises, and the time it stays high between and after frames. Before reset the bus clock may be slow, down to 1 MHz from an 8 MHz reference, so the half-bit time must cover at least 1 µs at that rate, and the guard is up to 16 reference cycles. A probe operation reads a fixed identity register and compares the result with an expected code. A build without the return line (`HAS_MISO = 0`) still runs every read on the bus, returns zero and flags the response as having no read-back.

The sequencer has states SQ_IDLE, SQ_INDEX and SQ_DATA. On acceptance it moves from SQ_IDLE to SQ_INDEX. When the first frame completes it moves from SQ_INDEX to SQ_DATA. When the second frame completes it moves from SQ_DATA back to SQ_IDLE with a response. The frame engine has states FR_IDLE, FR_LEAD, FR_LOW, FR_HIGH, FR_TRAIL and FR_GAP. A start moves it from FR_IDLE to FR_LEAD. When the guard expires it moves from FR_LEAD to FR_LOW. Each bit then moves from FR_LOW to FR_HIGH, and from FR_HIGH back to FR_LOW or, after bit 0, to FR_TRAIL. After the trailing guard it moves from FR_TRAIL to FR_GAP, and after the gap guard from FR_GAP to FR_IDLE with a done pulse.

Top module: `spi24_reg_master`

## Requirements
- R1: After reset, spi_cs_n, spi_sck and spi_mosi are all 1, busy is 0 and cmd_ready is 1. The bus keeps these idle levels whenever busy is 0.
- R2: A write (cmd_op 2'b00) sends frame {8'h70, 8'h00, cmd_reg} and then frame {8'h72, cmd_wdata}. Each frame is exactly 24 bits, most-significant bit first, and spi_mosi is valid at every rising edge of spi_sck.
- R3: A read (cmd_op 2'b01, and also 2'b11) sends {8'h70, 8'h00, cmd_reg} and then 24'h730000. rsp_data is the low 16 bits shifted in on spi_miso during the second frame. Each bit is sampled at the end of the low clock phase.
- R4: spi_cs_n stays low for one whole frame. spi_sck stays low for HALF_CYC cycles and high for HALF_CYC cycles per bit. Between the two frames of a request, spi_cs_n stays high for GUARD_CYC+2 cycles.
- R5: The first falling edge of spi_sck comes GUARD_CYC cycles after spi_cs_n falls. spi_cs_n rises HALF_CYC+GUARD_CYC cycles after the last rising edge of spi_sck.
- R6: busy rises the cycle after a request is accepted and falls GUARD_CYC+1 cycles after the final rise of spi_cs_n. In that same cycle rsp_valid pulses high for exactly one cycle. cmd_ready is 0 while busy, and requests offered during that time are ignored.
- R7: With HAS_MISO = 0, a read returns rsp_data 0 with rsp_noread 1, whatever spi_miso carries. A write returns rsp_noread 0.
- R8: A probe (cmd_op 2'b10) reads register ID_REG, whatever cmd_reg holds. rsp_id_ok is 1 exactly when the value read equals EXPECT_ID, and rsp_data carries that value.
- R9: A write response has rsp_data 0 and rsp_id_ok 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Request offered |
| cmd_ready | output | 1 | Request can be taken (idle) |
| cmd_op | input | 2 | 00 write, 10 probe, otherwise read |
| cmd_reg | input | 8 | Register index |
| cmd_wdata | input | 16 | Write value |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 16 | Read result, zero for writes |
| rsp_id_ok | output | 1 | Probe found the expected identity |
| rsp_noread | output | 1 | Read completed without a return line |
| busy | output | 1 | Request in progress |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data out, idles high |
| spi_miso | input | 1 | Serial data in, unused when HAS_MISO is 0 |

## Verification
The hardest case to reach is a request offered while another is in flight. cmd_ready is low then, so the request should never reach the bus. The bench holds cmd_valid high with a different operation for many cycles in the middle of a read and drops it well before the read ends. It then counts the frames a bus-side target model records and confirms that nothing follows. The sampling point of the return line is reached the same way: the target model changes spi_miso only on falling clock edges, so a read value comes back intact only if each bit is sampled in the low phase after the target has presented it.

// File: rtl/spi24_pkg.sv
package spi24_pkg;

    localparam logic [7:0] OPC_INDEX = 8'h70;
    localparam logic [7:0] OPC_WRITE = 8'h72;
    localparam logic [7:0] OPC_READ  = 8'h73;

    localparam int FRAME_BITS = 24;
    localparam int DATA_BITS  = 16;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b00,
        OP_READ  = 2'b01,
        OP_PROBE = 2'b10,
        OP_READX = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_LEAD,
        FR_LOW,
        FR_HIGH,
        FR_TRAIL,
        FR_GAP
    } frame_state_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_INDEX,
        SQ_DATA
    } seq_state_e;

endpackage

// File: rtl/spi24_sync.sv
module spi24_sync #(
    parameter bit HAS_MISO = 1'b1,
    parameter int STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    generate
        if (!HAS_MISO) begin : g_absent
            assign dout = 1'b0;
        end else if (STAGES == 0) begin : g_direct
            assign dout = din;
        end else begin : g_chain
            logic [STAGES-1:0] stage_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q <= '0;
                end else begin
                    stage_q[0] <= din;
                    for (int i = 1; i < STAGES; i++) begin
                        stage_q[i] <= stage_q[i-1];
                    end
                end
            end
            assign dout = stage_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/spi24_timer.sv
module spi24_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/spi24_frame.sv
module spi24_frame
    import spi24_pkg::*;
#(
    parameter int HALF_CYC  = 8,
    parameter int GUARD_CYC = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic                  miso_s,
    output logic                  done,
    output logic [FRAME_BITS-1:0] rx_word,
    output logic                  cs_n,
    output logic                  sck,
    output logic                  mosi
);
    localparam int MAXC = (HALF_CYC > GUARD_CYC) ? HALF_CYC : GUARD_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam int BW   = $clog2(FRAME_BITS);
    localparam logic [CW-1:0] HALF_M1  = CW'(HALF_CYC - 1);
    localparam logic [CW-1:0] GUARD_M1 = CW'(GUARD_CYC - 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);

    frame_state_e          state_q, state_n;
    logic                  tmr_zero, tmr_load;
    logic [CW-1:0]         tmr_val;
    logic [BW-1:0]         bit_q;
    logic [FRAME_BITS-1:0] sh_q, sh_n;
    logic                  active_n;

    spi24_timer #(.W(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            FR_IDLE:  if (start)    state_n = FR_LEAD;
            FR_LEAD:  if (tmr_zero) state_n = FR_LOW;
            FR_LOW:   if (tmr_zero) state_n = FR_HIGH;
            FR_HIGH:  if (tmr_zero) state_n = (bit_q == '0) ? FR_TRAIL : FR_LOW;
            FR_TRAIL: if (tmr_zero) state_n = FR_GAP;
            FR_GAP:   if (tmr_zero) state_n = FR_IDLE;
            default:  state_n = FR_IDLE;
        endcase
    end

    assign tmr_load = (state_n != state_q);
    assign tmr_val  = (state_n == FR_LOW || state_n == FR_HIGH) ? HALF_M1 : GUARD_M1;

    always_comb begin
        sh_n = sh_q;
        if (state_q == FR_IDLE && start) begin
            sh_n = frame;
        end else if (state_q == FR_HIGH && state_n == FR_LOW) begin
            sh_n = {sh_q[FRAME_BITS-2:0], 1'b0};
        end
    end

    assign active_n = (state_n == FR_LEAD) || (state_n == FR_LOW) ||
                      (state_n == FR_HIGH) || (state_n == FR_TRAIL);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FR_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // datapath: shift registers and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            rx_word <= '0;
            bit_q   <= '0;
        end else begin
            sh_q <= sh_n;
            if (state_q == FR_IDLE && start) begin
                rx_word <= '0;
                bit_q   <= LAST_BIT;
            end else if (state_q == FR_LOW && state_n == FR_HIGH) begin
                rx_word <= {rx_word[FRAME_BITS-2:0], miso_s};
            end else if (state_q == FR_HIGH && state_n == FR_LOW) begin
                bit_q <= bit_q - 1'b1;
            end
        end
    end

    // registered outputs decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n <= 1'b1;
            sck  <= 1'b1;
            mosi <= 1'b1;
            done <= 1'b0;
        end else begin
            cs_n <= ~active_n;
            sck  <= (state_n != FR_LOW);
            mosi <= active_n ? sh_n[FRAME_BITS-1] : 1'b1;
            done <= (state_q == FR_GAP) && (state_n == FR_IDLE);
        end
    end
endmodule

// File: rtl/spi24_seq.sv
module spi24_seq
    import spi24_pkg::*;
#(
    parameter bit             HAS_MISO  = 1'b1,
    parameter logic [7:0]     ID_REG    = 8'hB0,
    parameter logic [15:0]    EXPECT_ID = 16'h2828
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    output logic                  cmd_ready,
    input  logic [1:0]            cmd_op,
    input  logic [7:0]            cmd_reg,
    input  logic [DATA_BITS-1:0]  cmd_wdata,
    output logic                  rsp_valid,
    output logic [DATA_BITS-1:0]  rsp_data,
    output logic                  rsp_id_ok,
    output logic                  rsp_noread,
    output logic                  busy,
    output logic                  fe_start,
    output logic [FRAME_BITS-1:0] fe_frame,
    input  logic                  fe_done,
    input  logic [FRAME_BITS-1:0] fe_rx
);
    seq_state_e            state_q, state_n;
    op_e                   op_q;
    logic [DATA_BITS-1:0]  wdata_q;
    logic                  is_write, is_probe, new_write, new_probe;
    logic [DATA_BITS-1:0]  rd_val;

    assign is_write  = (op_q == OP_WRITE);
    assign is_probe  = (op_q == OP_PROBE);
    assign new_write = (op_e'(cmd_op) == OP_WRITE);
    assign new_probe = (op_e'(cmd_op) == OP_PROBE);
    assign rd_val    = HAS_MISO ? fe_rx[DATA_BITS-1:0] : '0;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            SQ_IDLE:  if (cmd_valid) state_n = SQ_INDEX;
            SQ_INDEX: if (fe_done)   state_n = SQ_DATA;
            SQ_DATA:  if (fe_done)   state_n = SQ_IDLE;
            default:  state_n = SQ_IDLE;
        endcase
    end

    assign cmd_ready = (state_q == SQ_IDLE);
    assign busy      = (state_q != SQ_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // outputs, frame launch and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q       <= OP_WRITE;
            wdata_q    <= '0;
            fe_start   <= 1'b0;
            fe_frame   <= '0;
            rsp_valid  <= 1'b0;
            rsp_data   <= '0;
            rsp_id_ok  <= 1'b0;
            rsp_noread <= 1'b0;
        end else begin
            fe_start  <= 1'b0;
            rsp_valid <= 1'b0;
            unique case (state_q)
                SQ_IDLE: begin
                    if (cmd_valid) begin
                        op_q     <= op_e'(cmd_op);
                        wdata_q  <= cmd_wdata;
                        fe_frame <= {OPC_INDEX, 8'h00, new_probe ? ID_REG : cmd_reg};
                        fe_start <= 1'b1;
                    end
                end
                SQ_INDEX: begin
                    if (fe_done) begin
                        fe_frame <= is_write ? {OPC_WRITE, wdata_q}
                                             : {OPC_READ, {DATA_BITS{1'b0}}};
                        fe_start <= 1'b1;
                    end
                end
                SQ_DATA: begin
                    if (fe_done) begin
                        rsp_valid  <= 1'b1;
                        rsp_data   <= is_write ? '0 : rd_val;
                        rsp_id_ok  <= is_probe && HAS_MISO && (rd_val == EXPECT_ID);
                        rsp_noread <= !is_write && !HAS_MISO;
                    end
                end
                default: ;
            endcase
        end
    end

    logic unused_new_write;
    assign unused_new_write = new_write;
endmodule

// File: rtl/spi24_reg_master.sv
module spi24_reg_master
    import spi24_pkg::*;
#(
    parameter int          HALF_CYC    = 8,
    parameter int          GUARD_CYC   = 16,
    parameter bit          HAS_MISO    = 1'b1,
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  ID_REG      = 8'hB0,
    parameter logic [15:0] EXPECT_ID   = 16'h2828
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic [1:0]  cmd_op,
    input  logic [7:0]  cmd_reg,
    input  logic [15:0] cmd_wdata,
    output logic        rsp_valid,
    output logic [15:0] rsp_data,
    output logic        rsp_id_ok,
    output logic        rsp_noread,
    output logic        busy,
    output logic        spi_cs_n,
    output logic        spi_sck,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    logic                  fe_start, fe_done, miso_s;
    logic [FRAME_BITS-1:0] fe_frame, fe_rx;

    spi24_sync #(.HAS_MISO(HAS_MISO), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (spi_miso),
        .dout  (miso_s)
    );

    spi24_seq #(.HAS_MISO(HAS_MISO), .ID_REG(ID_REG), .EXPECT_ID(EXPECT_ID)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_op     (cmd_op),
        .cmd_reg    (cmd_reg),
        .cmd_wdata  (cmd_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .rsp_id_ok  (rsp_id_ok),
        .rsp_noread (rsp_noread),
        .busy       (busy),
        .fe_start   (fe_start),
        .fe_frame   (fe_frame),
        .fe_done    (fe_done),
        .fe_rx      (fe_rx)
    );

    spi24_frame #(.HALF_CYC(HALF_CYC), .GUARD_CYC(GUARD_CYC)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (fe_start),
        .frame   (fe_frame),
        .miso_s  (miso_s),
        .done    (fe_done),
        .rx_word (fe_rx),
        .cs_n    (spi_cs_n),
        .sck     (spi_sck),
        .mosi    (spi_mosi)
    );
endmodule

// File: rtl/spi24_reg_master_chk.sv
module spi24_reg_master_chk #(
    parameter bit HAS_MISO = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic        rsp_valid,
    input logic [15:0] rsp_data,
    input logic        rsp_id_ok,
    input logic        busy,
    input logic        spi_cs_n,
    input logic        spi_sck,
    input logic        spi_mosi
);
    // R1
    idle_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (spi_cs_n && spi_sck && spi_mosi));

    // R4
    sck_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_sck) |-> !spi_cs_n);

    // R2
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && $past(!spi_cs_n) && !$fell(spi_sck)) |-> $stable(spi_mosi));

    // R6
    busy_from_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid && cmd_ready));

    // R6
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R6
    rsp_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!busy && spi_cs_n));

    // R7
    noread_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !HAS_MISO) |-> (rsp_data == 16'h0000 && !rsp_id_ok));
endmodule

bind spi24_reg_master spi24_reg_master_chk #(.HAS_MISO(HAS_MISO)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_id_ok (rsp_id_ok),
    .busy      (busy),
    .spi_cs_n  (spi_cs_n),
    .spi_sck   (spi_sck),
    .spi_mosi  (spi_mosi)
);

// File: tb/spi24_reg_master_tb.sv
`timescale 1ns/1ps
module spi24_reg_master_tb_top;
    localparam int HALF  = 8;
    localparam int GUARD = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [7:0]  cmd_reg = 8'h00;
    logic [15:0] cmd_wdata = 16'h0000;
    logic        cmd_ready, rsp_valid, rsp_id_ok, rsp_noread, busy;
    logic [15:0] rsp_data;
    logic        cs_n, sck, mosi;
    logic        miso = 1'b1;

    logic        nr_valid = 1'b0;
    logic [1:0]  nr_op = 2'b00;
    logic        nr_ready, nr_rsp_valid, nr_id_ok, nr_noread, nr_busy;
    logic [15:0] nr_data;
    logic        nr_cs_n, nr_sck, nr_mosi;

    spi24_reg_master #(.HALF_CYC(HALF), .GUARD_CYC(GUARD), .HAS_MISO(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_id_ok(rsp_id_ok),
        .rsp_noread(rsp_noread), .busy(busy), .spi_cs_n(cs_n), .spi_sck(sck),
        .spi_mosi(mosi), .spi_miso(miso)
    );

    spi24_reg_master #(.HALF_CYC(HALF), .GUARD_CYC(GUARD), .HAS_MISO(1'b0)) dut_nr_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(nr_valid), .cmd_ready(nr_ready),
        .cmd_op(nr_op), .cmd_reg(8'hB1), .cmd_wdata(16'h1111),
        .rsp_valid(nr_rsp_valid), .rsp_data(nr_data), .rsp_id_ok(nr_id_ok),
        .rsp_noread(nr_noread), .busy(nr_busy), .spi_cs_n(nr_cs_n), .spi_sck(nr_sck),
        .spi_mosi(nr_mosi), .spi_miso(1'b1)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // bus-side target model
    logic [15:0] sregs [256];
    logic [23:0] sh_in, resp;
    logic [23:0] frames [4];
    int          fbits [4];
    int          nbits = 0;
    int          fcount = 0;
    logic [7:0]  ptr = 8'h00;
    realtime     t_csf, t_csr, t_f, t_r, lead_t, low_t, high_t, trail_t, gap_t;

    initial begin
        for (int i = 0; i < 256; i++) sregs[i] = 16'(i * 16'h0101);
        sregs[8'hB0] = 16'h2828;
    end

    always @(negedge cs_n) begin
        if (fcount == 1) gap_t = $realtime - t_csr;
        t_csf = $realtime;
        nbits = 0;
        sh_in = 24'h0;
        resp  = (fcount == 1 && frames[0][23:16] == 8'h70) ? {8'h00, sregs[ptr]} : 24'h0;
        miso  = resp[23];
    end

    always @(posedge sck) begin
        if (!cs_n) begin
            sh_in  = {sh_in[22:0], mosi};
            nbits++;
            low_t  = $realtime - t_f;
            t_r    = $realtime;
        end
    end

    always @(negedge sck) begin
        if (!cs_n) begin
            if (nbits == 0) lead_t = $realtime - t_csf;
            else high_t = $realtime - t_r;
            t_f = $realtime;
            if (nbits > 0 && nbits < 24) miso = resp[23-nbits];
        end
    end

    always @(posedge cs_n) begin
        if (rst_n && nbits > 0) begin
            t_csr   = $realtime;
            trail_t = $realtime - t_r;
            if (fcount < 4) begin
                frames[fcount] = sh_in;
                fbits[fcount]  = nbits;
            end
            fcount++;
            if (sh_in[23:16] == 8'h70) ptr = sh_in[7:0];
            if (sh_in[23:16] == 8'h72) sregs[ptr] = sh_in[15:0];
            nbits = 0;
        end
    end

    function automatic int cyc(input realtime t);
        return int'(t / 4.0);
    endfunction

    logic [15:0] r_data;
    logic        r_id, r_nr;
    realtime     t_busy_fall;

    task automatic run_cmd(input logic [1:0] op, input logic [7:0] rg, input logic [15:0] wd);
        fcount = 0;
        @(negedge clk);
        cmd_op = op; cmd_reg = rg; cmd_wdata = wd; cmd_valid = 1'b1;
        do @(posedge clk); while (!cmd_ready);
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge busy);
        t_busy_fall = $realtime;
        @(negedge clk);
        r_data = rsp_data; r_id = rsp_id_ok; r_nr = rsp_noread;
        check(rsp_valid === 1'b1, "R6", "rsp_valid with busy fall", rsp_valid, 1);
    endtask

    task automatic t_reset();
        check({cs_n, sck, mosi} === 3'b111, "R1", "idle bus levels", {cs_n, sck, mosi}, 3'b111);
        check(busy === 1'b0 && cmd_ready === 1'b1, "R1", "busy/ready", {busy, cmd_ready}, 2'b01);
    endtask

    task automatic t_write();
        run_cmd(2'b00, 8'hB1, 16'hA55A);
        check(fcount == 2, "R2", "frame count", fcount, 2);
        check(frames[0] == 24'h7000B1, "R2", "index frame", frames[0], 24'h7000B1);
        check(frames[1] == 24'h72A55A, "R2", "write frame", frames[1], 24'h72A55A);
        check(fbits[0] == 24 && fbits[1] == 24, "R2", "bits per frame", fbits[1], 24);
        check(r_data == 16'h0 && r_id == 1'b0, "R9", "write response", {r_id, r_data}, 0);
        check(cyc(low_t) == HALF && cyc(high_t) == HALF, "R4", "clock phase", cyc(low_t), HALF);
        check(cyc(gap_t) == GUARD + 2, "R4", "inter-frame gap", cyc(gap_t), GUARD + 2);
        check(cyc(lead_t) == GUARD, "R5", "lead guard", cyc(lead_t), GUARD);
        check(cyc(trail_t) == HALF + GUARD, "R5", "trail guard", cyc(trail_t), HALF + GUARD);
        check(cyc(t_busy_fall - t_csr) == GUARD + 1, "R6", "busy end",
              cyc(t_busy_fall - t_csr), GUARD + 1);
        @(negedge clk);
        check(rsp_valid === 1'b0, "R6", "rsp pulse width", rsp_valid, 0);
        check({cs_n, sck, mosi} === 3'b111, "R1", "idle after write", {cs_n, sck, mosi}, 3'b111);
    endtask

    task automatic t_read(input logic [7:0] rg, input logic [15:0] val, input logic [1:0] op);
        run_cmd(2'b00, rg, val);
        run_cmd(op, rg, 16'hFFFF);
        check(frames[0] == {16'h7000, rg}, "R3", "read index frame", frames[0], {16'h7000, rg});
        check(frames[1] == 24'h730000, "R3", "read frame", frames[1], 24'h730000);
        check(r_data == val, "R3", "read value", r_data, val);
        check(r_nr == 1'b0, "R3", "noread flag", r_nr, 0);
    endtask

    task automatic t_ignore();
        fcount = 0;
        @(negedge clk);
        cmd_op = 2'b01; cmd_reg = 8'hC4; cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_op = 2'b00; cmd_reg = 8'h55; cmd_wdata = 16'hDEAD;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            check(cmd_ready === 1'b0, "R6", "ready low while busy", cmd_ready, 0);
        end
        cmd_valid = 1'b0;
        @(negedge busy);
        repeat (200) @(negedge clk);
        check(fcount == 2, "R6", "offered request ignored", fcount, 2);
        check(frames[0] == 24'h7000C4, "R6", "first request kept", frames[0], 24'h7000C4);
        check(sregs[8'h55] == 16'h5555, "R6", "ignored write absent", sregs[8'h55], 16'h5555);
    endtask

    task automatic t_probe();
        run_cmd(2'b10, 8'h12, 16'h0);
        check(frames[0] == 24'h7000B0, "R8", "probe index", frames[0], 24'h7000B0);
        check(r_id == 1'b1 && r_data == 16'h2828, "R8", "probe match", {r_id, r_data}, 17'h12828);
        run_cmd(2'b00, 8'hB0, 16'h1234);
        run_cmd(2'b10, 8'h00, 16'h0);
        check(r_id == 1'b0 && r_data == 16'h1234, "R8", "probe mismatch", {r_id, r_data}, 17'h01234);
    endtask

    task automatic nr_cmd(input logic [1:0] op);
        @(negedge clk);
        nr_op = op; nr_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        nr_valid = 1'b0;
        @(negedge nr_busy);
        @(negedge clk);
        check(nr_rsp_valid === 1'b1, "R7", "no-input response", nr_rsp_valid, 1);
    endtask

    task automatic t_noread();
        nr_cmd(2'b01);
        check(nr_data == 16'h0 && nr_noread == 1'b1, "R7", "read without line",
              {nr_noread, nr_data}, 17'h10000);
        nr_cmd(2'b00);
        check(nr_noread == 1'b0, "R7", "write noread flag", nr_noread, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #600000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_write();
        t_read(8'hC4, 16'h0001, 2'b01);
        t_read(8'h3C, 16'hFFFF, 2'b11);
        t_read(8'h07, 16'h8000, 2'b01);
        t_ignore();
        t_probe();
        t_noread();
        finish_run();
    end
endmodule